// File: doc/BRIEF.md
# Power-Management Event Status and System Control Interrupt Generator

This block holds the sixteen-bit power-management event status word of a chip and drives the system control interrupt (SCI) from it. Hardware event pulses arrive from the power button, the power-button override detector, the real-time-clock alarm and a parameterised set of wake sources. The block also takes the current system power state, which is working, sleep or soft-off. Each event latches a status bit that software clears by writing one. Some of the latched bits reach SCI only when both their own enable and a global SCI enable are set. The rest reach it unconditionally.

While the system is asleep, a power-button press or an enabled wake source latches the wake status bit. It also sends a one-cycle wake request to the external state controller, which brings the system back to working. Software reaches four small registers through a plain select/write/read port: status, event enable, control and wake-source enable. Writing one to the release bit in the control register latches the global-lock status bit.

Top module: `pm_event_hub`

## Requirements
- R1: After synchronous reset, all four registers read 0000h, and `sci` and `wake_req` are low.
- R2: Only status bits 15 (wake), 11 (override), 10 (RTC alarm), 8 (power button) and 5 (global lock) can ever read as one. In the event-enable register (select 1), only bits 10, 8 and 5 hold a value. In the wake-enable register (select 3), only the low NUM_WAKE bits hold a value. Every other bit reads zero.
- R3: A write to the status register (select 0) clears each bit written as one and leaves each bit written as zero unchanged.
- R4: An RTC alarm or override pulse sets its status bit on the next edge, whatever the enable settings are.
- R5: Bits 10, 8 and 5 drive `sci` only while the matching event-enable bit (10, 8 or 5) is set and the global SCI enable (control bit 0, select 2) is set.
- R6: Status bits 15 and 11 drive `sci` with no enable needed.
- R7: In the working state (`sys_state` 00), a button press sets bit 8 and issues no wake. In sleep (01) or soft-off (10, with 11 treated the same way), a press sets bit 15 instead of bit 8 and issues a wake, whatever event-enable bit 8 holds.
- R8: While asleep, a wake-source pulse sets bit 15 and issues a wake only if its wake-enable bit is set. In the working state, wake sources have no effect.
- R9: Writing one to control bit 1 sets status bit 5 on the next edge. Control bit 1 always reads zero.
- R10: When a hardware event and a software clear hit the same status bit in one cycle, the bit ends up set.
- R11: `wake_req` is high for exactly one cycle for each qualifying wake event. It rises only on the edge after an event seen in a non-working state.
- R12: `sci` is a level output: it falls on the same edge at which the last qualifying status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_state | input | 2 | Power state: 00 working, 01 sleep, 10 soft-off, 11 treated as sleep |
| pwrbtn_evt | input | 1 | One-cycle power-button press pulse |
| ovr_evt | input | 1 | One-cycle power-button override pulse |
| rtc_evt | input | 1 | One-cycle RTC alarm pulse |
| wake_src | input | NUM_WAKE | One-cycle wake-source pulses |
| reg_sel | input | 2 | Register select: 0 status, 1 event enable, 2 control, 3 wake enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| sci | output | 1 | System control interrupt level |
| wake_req | output | 1 | One-cycle wake request to the state controller |

## Verification
The bench builds the block with NUM_WAKE set to 3 rather than the default 4. With three sources, a write of all ones to the wake-enable register shows that bits 3 and above are discarded. The narrower width also lets the bench enable a single source and check that a neighbouring source stays ignored. The scoreboard model is written from the requirements. It predicts the read data, `sci` and `wake_req` after every cycle, so the R10 collision case, the soft-off button press and the clear that drops `sci` are each checked at the exact edge where they take effect.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    localparam int REG_W = 16;

    localparam int B_WAKE = 15;
    localparam int B_OVR  = 11;
    localparam int B_RTC  = 10;
    localparam int B_PB   = 8;
    localparam int B_GBL  = 5;

    localparam int C_SCIEN = 0;
    localparam int C_BREL  = 1;

    localparam logic [REG_W-1:0] STAT_IMPL   = (REG_W'(1) << B_WAKE) | (REG_W'(1) << B_OVR) |
                                               (REG_W'(1) << B_RTC)  | (REG_W'(1) << B_PB)  |
                                               (REG_W'(1) << B_GBL);
    localparam logic [REG_W-1:0] ALWAYS_MASK = (REG_W'(1) << B_WAKE) | (REG_W'(1) << B_OVR);
    localparam logic [REG_W-1:0] GATED_MASK  = (REG_W'(1) << B_RTC) | (REG_W'(1) << B_PB) |
                                               (REG_W'(1) << B_GBL);

    typedef enum logic [1:0] {
        PS_WORK    = 2'b00,
        PS_SLEEP   = 2'b01,
        PS_SOFTOFF = 2'b10,
        PS_RSVD    = 2'b11
    } pwr_state_e;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_EVEN = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_WKEN = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pwrbtn;
        logic ovr;
        logic rtc;
        logic brel;
    } hw_evt_t;

    function automatic logic is_asleep(pwr_state_e s);
        return s != PS_WORK;
    endfunction

endpackage

// File: rtl/pm_evt_capture.sv
module pm_evt_capture
    import pm_event_pkg::*;
#(
    parameter int NUM_WAKE = 4
) (
    input  pwr_state_e           state,
    input  hw_evt_t              evt,
    input  logic [NUM_WAKE-1:0]  wake_src,
    input  logic [NUM_WAKE-1:0]  wake_en,
    output logic [REG_W-1:0]     set_vec,
    output logic                 wake_hit
);
    logic [NUM_WAKE-1:0] src_q;
    logic                asleep;

    assign asleep = is_asleep(state);

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
        assign src_q[i] = wake_src[i] & wake_en[i];
    end

    always_comb begin
        wake_hit = asleep && (evt.pwrbtn || (|src_q));
        set_vec  = '0;
        set_vec[B_OVR]  = evt.ovr;
        set_vec[B_RTC]  = evt.rtc;
        set_vec[B_PB]   = evt.pwrbtn && !asleep;
        set_vec[B_GBL]  = evt.brel;
        set_vec[B_WAKE] = wake_hit;
    end
endmodule

// File: rtl/pm_stat_reg.sv
module pm_stat_reg
    import pm_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] status
);
    logic [REG_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= ((status_q & ~clr_vec) | set_vec) & STAT_IMPL;
    end

    assign status = status_q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & STAT_IMPL)) |=> ((status_q & $past(set_vec & STAT_IMPL)) == $past(set_vec & STAT_IMPL)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~STAT_IMPL) == '0);
endmodule

// File: rtl/pm_sci_qual.sv
module pm_sci_qual
    import pm_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] evt_en,
    input  logic             sci_en,
    output logic             sci
);
    logic [REG_W-1:0] qual;

    always_comb begin
        qual = status & ALWAYS_MASK;
        if (sci_en) qual = qual | (status & evt_en & GATED_MASK);
    end

    assign sci = |qual;

    // R6
    always_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(status & ALWAYS_MASK)) |-> sci);

    // R12
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !sci);

    // R5
    gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!sci_en && ((status & ALWAYS_MASK) == '0)) |-> !sci);
endmodule

// File: rtl/pm_event_hub.sv
module pm_event_hub
    import pm_event_pkg::*;
#(
    parameter int NUM_WAKE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          sys_state,
    input  logic                pwrbtn_evt,
    input  logic                ovr_evt,
    input  logic                rtc_evt,
    input  logic [NUM_WAKE-1:0] wake_src,
    input  logic [1:0]          reg_sel,
    input  logic                reg_wr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic                sci,
    output logic                wake_req
);
    localparam int WK_W = NUM_WAKE;

    pwr_state_e       state;
    reg_sel_e         sel;
    hw_evt_t          evt;
    logic [REG_W-1:0] evt_en_q;
    logic             sci_en_q;
    logic [WK_W-1:0]  wken_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status;
    logic             wake_hit;
    logic             wake_q;

    assign state = pwr_state_e'(sys_state);
    assign sel   = reg_sel_e'(reg_sel);

    always_comb begin
        evt.pwrbtn = pwrbtn_evt;
        evt.ovr    = ovr_evt;
        evt.rtc    = rtc_evt;
        evt.brel   = reg_wr && (sel == SEL_CTRL) && reg_wdata[C_BREL];
        clr_vec    = (reg_wr && (sel == SEL_STAT)) ? reg_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_en_q <= '0;
            sci_en_q <= 1'b0;
            wken_q   <= '0;
            wake_q   <= 1'b0;
        end else begin
            wake_q <= wake_hit;
            if (reg_wr) begin
                case (sel)
                    SEL_EVEN: evt_en_q <= reg_wdata & GATED_MASK;
                    SEL_CTRL: sci_en_q <= reg_wdata[C_SCIEN];
                    SEL_WKEN: wken_q   <= reg_wdata[WK_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    pm_evt_capture #(.NUM_WAKE(NUM_WAKE)) u_capture (
        .state    (state),
        .evt      (evt),
        .wake_src (wake_src),
        .wake_en  (wken_q),
        .set_vec  (set_vec),
        .wake_hit (wake_hit)
    );

    pm_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status)
    );

    pm_sci_qual u_sci (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .evt_en (evt_en_q),
        .sci_en (sci_en_q),
        .sci    (sci)
    );

    always_comb begin
        case (sel)
            SEL_STAT: reg_rdata = status;
            SEL_EVEN: reg_rdata = evt_en_q;
            SEL_CTRL: reg_rdata = REG_W'(sci_en_q);
            default:  reg_rdata = REG_W'(wken_q);
        endcase
    end

    assign wake_req = wake_q;

    // R7
    pb_working_chk: assert property (@(posedge clk) disable iff (rst)
        (pwrbtn_evt && (sys_state == 2'b00)) |=> (status[B_PB] && !wake_req));

    // R7
    pb_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (pwrbtn_evt && (sys_state != 2'b00)) |=> (status[B_WAKE] && wake_req));

    // R11
    wake_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> ($past(sys_state) != 2'b00));

    // R9
    brel_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_sel == 2'd2) && reg_wdata[1]) |=> status[B_GBL]);
endmodule

// File: tb/pm_event_hub_bench.sv
module pm_event_hub_bench;
    localparam int NW = 3;

    typedef struct {
        string       tag;
        logic [15:0] rdata;
        logic        sci;
        logic        wake;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    sys_state = 2'b00;
    logic          pwrbtn_evt = 1'b0, ovr_evt = 1'b0, rtc_evt = 1'b0;
    logic [NW-1:0] wake_src = '0;
    logic [1:0]    reg_sel = 2'd0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          sci, wake_req;

    int checks = 0;
    int failures = 0;
    exp_t sb[$];

    logic [15:0]   m_stat = '0, m_en = '0;
    logic          m_scien = 1'b0;
    logic [NW-1:0] m_wken = '0;

    always #5 clk = ~clk;

    pm_event_hub #(.NUM_WAKE(NW)) u_pm_event_hub (
        .clk(clk), .rst(rst), .sys_state(sys_state), .pwrbtn_evt(pwrbtn_evt),
        .ovr_evt(ovr_evt), .rtc_evt(rtc_evt), .wake_src(wake_src), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci(sci),
        .wake_req(wake_req)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic [1:0] sel, logic wr, logic [15:0] wd,
                        logic [1:0] st, logic pb, logic ov, logic rt, logic [NW-1:0] wk);
        logic [15:0] setv, clrv;
        logic        asl, wh;
        exp_t        e;
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_wdata = wd; sys_state = st;
        pwrbtn_evt = pb; ovr_evt = ov; rtc_evt = rt; wake_src = wk;
        asl  = (st != 2'b00);
        wh   = asl && (pb || (|(wk & m_wken)));
        setv = '0;
        setv[11] = ov;
        setv[10] = rt;
        setv[8]  = pb && !asl;
        setv[5]  = wr && (sel == 2'd2) && wd[1];
        setv[15] = wh;
        clrv = (wr && sel == 2'd0) ? wd : 16'h0000;
        m_stat = ((m_stat & ~clrv) | setv) & 16'h8D20;
        if (wr && sel == 2'd1) m_en = wd & 16'h0520;
        if (wr && sel == 2'd2) m_scien = wd[0];
        if (wr && sel == 2'd3) m_wken = wd[NW-1:0];
        e.tag  = tag;
        e.sci  = (|(m_stat & 16'h8800)) || (m_scien && (|(m_stat & m_en)));
        e.wake = wh;
        case (sel)
            2'd0:    e.rdata = m_stat;
            2'd1:    e.rdata = m_en;
            2'd2:    e.rdata = {15'h0, m_scien};
            default: e.rdata = 16'(m_wken);
        endcase
        sb.push_back(e);
    endtask

    task automatic idle(string tag, logic [1:0] sel, logic [1:0] st);
        step(tag, sel, 1'b0, 16'h0, st, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic wr(string tag, logic [1:0] sel, logic [15:0] wd);
        step(tag, sel, 1'b1, wd, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    endtask

    // monitor: pops one expectation per cycle, sampled 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "rdata", reg_rdata, e.rdata);
                chk(e.tag, "sci", {15'h0, sci}, {15'h0, e.sci});
                chk(e.tag, "wake_req", {15'h0, wake_req}, {15'h0, e.wake});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset values of all four registers
        idle("R1", 2'd0, 2'b00);
        idle("R1", 2'd1, 2'b00);
        idle("R1", 2'd2, 2'b00);
        idle("R1", 2'd3, 2'b00);
        // R2 unimplemented bits stay zero
        wr("R2", 2'd1, 16'hFFFF);
        wr("R2", 2'd3, 16'hFFFF);
        wr("R2", 2'd0, 16'hFFFF);
        wr("R2", 2'd1, 16'h0000);
        wr("R2", 2'd3, 16'h0000);
        // R4 RTC latches with everything disabled
        step("R4", 2'd0, 1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b1, '0);
        // R3 zero write keeps, one write clears
        wr("R3", 2'd0, 16'h0000);
        wr("R3", 2'd0, 16'h0400);
        // R5 gated path
        step("R5", 2'd0, 1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b1, '0);
        wr("R5", 2'd1, 16'h0400);
        wr("R5", 2'd2, 16'h0001);
        wr("R5", 2'd1, 16'h0000);
        wr("R5", 2'd1, 16'h0400);
        wr("R5", 2'd2, 16'h0000);
        wr("R5", 2'd2, 16'h0001);
        wr("R12", 2'd0, 16'h0400);
        wr("R5", 2'd2, 16'h0000);
        wr("R5", 2'd1, 16'h0000);
        // R6 override with no enables
        step("R6", 2'd0, 1'b0, 16'h0, 2'b00, 1'b0, 1'b1, 1'b0, '0);
        wr("R12", 2'd0, 16'h0800);
        // R7 button in working state
        step("R7", 2'd0, 1'b0, 16'h0, 2'b00, 1'b1, 1'b0, 1'b0, '0);
        wr("R7", 2'd0, 16'h0100);
        // R7 button in sleep and soft-off
        step("R7", 2'd0, 1'b0, 16'h0, 2'b01, 1'b1, 1'b0, 1'b0, '0);
        idle("R11", 2'd0, 2'b01);
        wr("R12", 2'd0, 16'h8000);
        step("R7", 2'd0, 1'b0, 16'h0, 2'b10, 1'b1, 1'b0, 1'b0, '0);
        idle("R11", 2'd0, 2'b10);
        wr("R7", 2'd0, 16'h8000);
        // R8 wake sources
        step("R8", 2'd0, 1'b0, 16'h0, 2'b01, 1'b0, 1'b0, 1'b0, 3'b111);
        wr("R8", 2'd3, 16'h0002);
        step("R8", 2'd0, 1'b0, 16'h0, 2'b01, 1'b0, 1'b0, 1'b0, 3'b001);
        step("R8", 2'd0, 1'b0, 16'h0, 2'b01, 1'b0, 1'b0, 1'b0, 3'b010);
        idle("R11", 2'd0, 2'b01);
        wr("R8", 2'd0, 16'h8000);
        step("R8", 2'd0, 1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, 3'b010);
        step("R11", 2'd0, 1'b0, 16'h0, 2'b11, 1'b0, 1'b0, 1'b0, 3'b010);
        step("R11", 2'd0, 1'b0, 16'h0, 2'b11, 1'b0, 1'b0, 1'b0, 3'b010);
        wr("R8", 2'd0, 16'h8000);
        // R9 release bit
        wr("R9", 2'd2, 16'h0002);
        idle("R9", 2'd0, 2'b00);
        wr("R9", 2'd1, 16'h0020);
        wr("R9", 2'd2, 16'h0001);
        wr("R12", 2'd0, 16'h0020);
        // R10 set beats clear
        step("R10", 2'd0, 1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b1, '0);
        step("R10", 2'd0, 1'b1, 16'h0400, 2'b00, 1'b0, 1'b0, 1'b1, '0);
        wr("R10", 2'd0, 16'hFFFF);
        idle("R1", 2'd0, 2'b00);
        @(negedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule